// File: doc/BRIEF.md
# Bus-Based Fetch and Address Datapath

This block is the register-transfer datapath that a microcoded or hard-wired control sequencer steers, one state per clock. It holds four registers: the program counter, the memory address register, the memory data register and the instruction register. It also holds a word-wide memory array. Four sources can drive one shared word-wide bus: the PC, the MDR, an ALU result port, and an effective-address adder. Each source has its own drive enable, and the bus is built as an AND-OR mux. The register file and the ALU are outside the block. Their base-register read value and their result enter on ports.

The effective-address adder sums two operands, and each operand has its own encoded select. The first operand is the PC or the register-file base value. The second operand is zero or one of two sign-extended offset fields of the instruction register. The PC is pre-incremented during fetch, so any PC-relative address is formed from the address of the next instruction. Three one-bit condition flags (negative, zero, positive) can be loaded from the bus. They are compared against the instruction's condition mask to give a branch-taken signal.

Every select and every enable acts within the current cycle. Registers and memory capture at the rising edge that ends the cycle. The block has no data stream interface, so no valid/ready handshake applies. All pins are plain control or status pins.

Top module: `bus_addr_datapath`

## Requirements
- R1: After reset, PC, MAR, MDR and IR read zero. Of the condition flags, only the zero flag is set, so an IR mask of 010 (IR[10] alone) gives br_taken = 1 and a mask of 101 gives 0.
- R2: bus_out equals PC when drv_pc is set, MDR when drv_mdr is set, alu_result when drv_alu is set, and the adder result when drv_ea is set. bus_out is zero when no enable is set. The user keeps at most one enable set per cycle.
- R3: The first adder operand is PC when ea_base_sel = 0 and rf_base_data when ea_base_sel = 1.
- R4: The second adder operand is selected by ea_ofs_sel: 00 gives zero, 01 gives IR[5:0] sign-extended, 10 gives IR[8:0] sign-extended, and 11 gives zero. The sum wraps modulo 2^16.
- R5: At an edge with pc_load set, PC takes PC+1 when pc_src_sel = 00 and the adder result when it is 01. It keeps its value when pc_src_sel is 10 or 11. Without pc_load, PC holds.
- R6: MAR captures bus_out at an edge with mar_load set. IR captures bus_out at an edge with ir_load set. Each register holds otherwise.
- R7: At an edge with mdr_load set, MDR captures the memory word at MAR when mdr_src_sel = 1 and bus_out when mdr_src_sel = 0. MDR holds otherwise.
- R8: At an edge with mem_wr set, the memory stores the pre-edge MDR at the location given by the low AW bits of MAR. Reads present the addressed word without delay, so the MAR upper bits alias.
- R9: At an edge with cc_load set, the flags take the sign state of bus_out. A set bit 15 sets N only, an all-zero value sets Z only, and any other value sets P only. Otherwise the flags hold.
- R10: br_taken = (IR[11] & N) | (IR[10] & Z) | (IR[9] & P), taken from the current registers with no added delay.
- R11: In a fetch sequence (PC to MAR; memory to MDR with PC+1; MDR to IR), IR receives the word at the old PC. A following PC-relative address is formed from the incremented PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| drv_pc | input | 1 | PC drives the bus |
| drv_mdr | input | 1 | MDR drives the bus |
| drv_alu | input | 1 | ALU result drives the bus |
| drv_ea | input | 1 | Address adder drives the bus |
| ea_base_sel | input | 1 | First adder operand: 0 PC, 1 base register |
| ea_ofs_sel | input | 2 | Second adder operand select |
| pc_src_sel | input | 2 | PC next-value select |
| pc_load | input | 1 | PC load enable |
| mar_load | input | 1 | MAR load enable |
| mdr_load | input | 1 | MDR load enable |
| mdr_src_sel | input | 1 | MDR source: 1 memory, 0 bus |
| ir_load | input | 1 | IR load enable |
| mem_wr | input | 1 | Memory write strobe |
| cc_load | input | 1 | Condition flag load enable |
| rf_base_data | input | 16 | Base register value from register file |
| alu_result | input | 16 | Result from external ALU |
| bus_out | output | 16 | Shared bus value |
| pc_out | output | 16 | Program counter |
| mar_out | output | 16 | Memory address register |
| mdr_out | output | 16 | Memory data register |
| ir_out | output | 16 | Instruction register |
| br_taken | output | 1 | Branch condition met |

## Verification
The bench builds the block with a 16-bit word and an address width of 6, giving a 64-word memory. At that width the MAR bits above bit 5 are dropped from the address, so a bench write to one address can be read back through an alias 64 words higher. The small depth also lets the randomized phase return to locations it has already written. The remaining widths keep their defaults. With these values the bench reaches the sign boundaries of both offset fields and the wrap of the adder sum.

// File: rtl/dp_pkg.sv
`timescale 1ns/1ps
package dp_pkg;
  // Encoding of the second adder operand select
  typedef enum logic [1:0] {
    OFS_ZERO  = 2'b00,
    OFS_SHORT = 2'b01,
    OFS_LONG  = 2'b10,
    OFS_RSVD  = 2'b11
  } ofs_sel_e;

  // Encoding of the PC next-value select
  typedef enum logic [1:0] {
    PCS_INC    = 2'b00,
    PCS_EA     = 2'b01,
    PCS_HOLD_A = 2'b10,
    PCS_HOLD_B = 2'b11
  } pc_src_e;

  // Bus source slots
  localparam int unsigned N_BUS_SRC = 4;
  localparam int unsigned SRC_PC    = 0;
  localparam int unsigned SRC_MDR   = 1;
  localparam int unsigned SRC_ALU   = 2;
  localparam int unsigned SRC_EA    = 3;

  // Offset field widths within the instruction word
  localparam int unsigned SHORT_OFS_W = 6;
  localparam int unsigned LONG_OFS_W  = 9;
endpackage

// File: rtl/dp_bus_mux.sv
`timescale 1ns/1ps
module dp_bus_mux #(
  parameter int DW   = 16,
  parameter int NSRC = 4
) (
  input  logic [NSRC-1:0]         drive_en,
  input  logic [NSRC-1:0][DW-1:0] src_val,
  output logic [DW-1:0]           bus_val
);
  logic [NSRC-1:0][DW-1:0] gated;

  for (genvar g = 0; g < NSRC; g++) begin : g_gate
    assign gated[g] = src_val[g] & {DW{drive_en[g]}};
  end

  always_comb begin
    bus_val = '0;
    for (int i = 0; i < NSRC; i++) bus_val = bus_val | gated[i];
  end
endmodule

// File: rtl/dp_ea_unit.sv
`timescale 1ns/1ps
module dp_ea_unit
  import dp_pkg::*;
#(
  parameter int DW      = 16,
  parameter int SHORT_W = 6,
  parameter int LONG_W  = 9
) (
  input  logic [DW-1:0]     pc_val,
  input  logic [DW-1:0]     base_val,
  input  logic [LONG_W-1:0] ofs_field,
  input  logic              base_sel,
  input  logic [1:0]        ofs_sel,
  output logic [DW-1:0]     ea_val
);
  localparam int SHORT_PAD = DW - SHORT_W;
  localparam int LONG_PAD  = DW - LONG_W;

  logic [DW-1:0] sx_short, sx_long, opnd_a, opnd_b;

  assign sx_short = {{SHORT_PAD{ofs_field[SHORT_W-1]}}, ofs_field[SHORT_W-1:0]};
  assign sx_long  = {{LONG_PAD{ofs_field[LONG_W-1]}}, ofs_field};
  assign opnd_a   = base_sel ? base_val : pc_val;

  always_comb begin
    case (ofs_sel_e'(ofs_sel))
      OFS_SHORT: opnd_b = sx_short;
      OFS_LONG:  opnd_b = sx_long;
      default:   opnd_b = '0;
    endcase
  end

  assign ea_val = opnd_a + opnd_b;
endmodule

// File: rtl/dp_cond_unit.sv
`timescale 1ns/1ps
module dp_cond_unit #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cc_load,
  input  logic [DW-1:0] bus_val,
  input  logic [2:0]    test_mask,
  output logic [2:0]    flags,
  output logic          taken
);
  // flags ordering: {neg, zero, pos}
  localparam logic [2:0] FLAG_NEG  = 3'b100;
  localparam logic [2:0] FLAG_ZERO = 3'b010;
  localparam logic [2:0] FLAG_POS  = 3'b001;

  logic [2:0] flags_next;

  always_comb begin
    if (bus_val[DW-1])      flags_next = FLAG_NEG;
    else if (bus_val == '0) flags_next = FLAG_ZERO;
    else                    flags_next = FLAG_POS;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       flags <= FLAG_ZERO;
    else if (cc_load) flags <= flags_next;
  end

  assign taken = |(test_mask & flags);
endmodule

// File: rtl/dp_word_mem.sv
`timescale 1ns/1ps
module dp_word_mem #(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[addr] <= wdata;
  end

  assign rdata = store[addr];
endmodule

// File: rtl/bus_addr_datapath.sv
`timescale 1ns/1ps
module bus_addr_datapath
  import dp_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          drv_pc,
  input  logic          drv_mdr,
  input  logic          drv_alu,
  input  logic          drv_ea,
  input  logic          ea_base_sel,
  input  logic [1:0]    ea_ofs_sel,
  input  logic [1:0]    pc_src_sel,
  input  logic          pc_load,
  input  logic          mar_load,
  input  logic          mdr_load,
  input  logic          mdr_src_sel,
  input  logic          ir_load,
  input  logic          mem_wr,
  input  logic          cc_load,
  input  logic [DW-1:0] rf_base_data,
  input  logic [DW-1:0] alu_result,
  output logic [DW-1:0] bus_out,
  output logic [DW-1:0] pc_out,
  output logic [DW-1:0] mar_out,
  output logic [DW-1:0] mdr_out,
  output logic [DW-1:0] ir_out,
  output logic          br_taken
);
  localparam logic [DW-1:0] PC_STEP = DW'(1);
  localparam int            MASK_HI = 11;
  localparam int            MASK_LO = 9;

  logic [DW-1:0] pc_q, mar_q, mdr_q, ir_q;
  logic [DW-1:0] pc_next, mdr_next;
  logic [DW-1:0] ea_val, mem_rdata, bus_val;
  logic [2:0]    cc_flags;

  logic [N_BUS_SRC-1:0]         drive_en;
  logic [N_BUS_SRC-1:0][DW-1:0] src_val;

  always_comb begin
    drive_en          = '0;
    drive_en[SRC_PC]  = drv_pc;
    drive_en[SRC_MDR] = drv_mdr;
    drive_en[SRC_ALU] = drv_alu;
    drive_en[SRC_EA]  = drv_ea;
    src_val           = '0;
    src_val[SRC_PC]   = pc_q;
    src_val[SRC_MDR]  = mdr_q;
    src_val[SRC_ALU]  = alu_result;
    src_val[SRC_EA]   = ea_val;
  end

  dp_bus_mux #(.DW(DW), .NSRC(N_BUS_SRC)) u_bus (
    .drive_en (drive_en),
    .src_val  (src_val),
    .bus_val  (bus_val)
  );

  dp_ea_unit #(.DW(DW), .SHORT_W(SHORT_OFS_W), .LONG_W(LONG_OFS_W)) u_ea (
    .pc_val    (pc_q),
    .base_val  (rf_base_data),
    .ofs_field (ir_q[LONG_OFS_W-1:0]),
    .base_sel  (ea_base_sel),
    .ofs_sel   (ea_ofs_sel),
    .ea_val    (ea_val)
  );

  dp_cond_unit #(.DW(DW)) u_cc (
    .clk       (clk),
    .rst_n     (rst_n),
    .cc_load   (cc_load),
    .bus_val   (bus_val),
    .test_mask (ir_q[MASK_HI:MASK_LO]),
    .flags     (cc_flags),
    .taken     (br_taken)
  );

  dp_word_mem #(.DW(DW), .AW(AW)) u_mem (
    .clk   (clk),
    .wr_en (mem_wr),
    .addr  (mar_q[AW-1:0]),
    .wdata (mdr_q),
    .rdata (mem_rdata)
  );

  always_comb begin
    case (pc_src_e'(pc_src_sel))
      PCS_INC: pc_next = pc_q + PC_STEP;
      PCS_EA:  pc_next = ea_val;
      default: pc_next = pc_q;
    endcase
  end

  assign mdr_next = mdr_src_sel ? mem_rdata : bus_val;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_q  <= '0;
      mar_q <= '0;
      mdr_q <= '0;
      ir_q  <= '0;
    end else begin
      if (pc_load)  pc_q  <= pc_next;
      if (mar_load) mar_q <= bus_val;
      if (mdr_load) mdr_q <= mdr_next;
      if (ir_load)  ir_q  <= bus_val;
    end
  end

  assign bus_out = bus_val;
  assign pc_out  = pc_q;
  assign mar_out = mar_q;
  assign mdr_out = mdr_q;
  assign ir_out  = ir_q;
endmodule

// File: rtl/dp_checker.sv
`timescale 1ns/1ps
module dp_checker #(
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          drv_pc,
  input logic          drv_mdr,
  input logic          drv_alu,
  input logic          drv_ea,
  input logic          pc_load,
  input logic [1:0]    pc_src_sel,
  input logic          mar_load,
  input logic          mdr_load,
  input logic          mdr_src_sel,
  input logic          ir_load,
  input logic [DW-1:0] bus_out,
  input logic [DW-1:0] pc_out,
  input logic [DW-1:0] mar_out,
  input logic [DW-1:0] mdr_out,
  input logic [DW-1:0] ir_out,
  input logic [2:0]    cc_flags
);
  localparam logic [DW-1:0] ONE = DW'(1);

  AST_DRIVE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({drv_pc, drv_mdr, drv_alu, drv_ea})); // R2

  AST_BUS_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !(drv_pc | drv_mdr | drv_alu | drv_ea) |-> bus_out == '0); // R2

  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_load |=> $stable(pc_out)); // R5

  AST_PC_INCREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_load && pc_src_sel == 2'b00) |=> pc_out == $past(pc_out) + ONE); // R5

  AST_MAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    mar_load |=> mar_out == $past(bus_out)); // R6

  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ir_load |=> $stable(ir_out)); // R6

  AST_MDR_FROM_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (mdr_load && !mdr_src_sel) |=> mdr_out == $past(bus_out)); // R7

  AST_FLAGS_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cc_flags)); // R9
endmodule

bind bus_addr_datapath dp_checker #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .drv_pc      (drv_pc),
  .drv_mdr     (drv_mdr),
  .drv_alu     (drv_alu),
  .drv_ea      (drv_ea),
  .pc_load     (pc_load),
  .pc_src_sel  (pc_src_sel),
  .mar_load    (mar_load),
  .mdr_load    (mdr_load),
  .mdr_src_sel (mdr_src_sel),
  .ir_load     (ir_load),
  .bus_out     (bus_out),
  .pc_out      (pc_out),
  .mar_out     (mar_out),
  .mdr_out     (mdr_out),
  .ir_out      (ir_out),
  .cc_flags    (cc_flags)
);

// File: tb/tb_bus_addr_datapath.sv
`timescale 1ns/1ps
module tb_bus_addr_datapath;
  localparam int DW = 16;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rst_n;
  logic drv_pc, drv_mdr, drv_alu, drv_ea, ea_base_sel;
  logic [1:0] ea_ofs_sel, pc_src_sel;
  logic pc_load, mar_load, mdr_load, mdr_src_sel, ir_load, mem_wr, cc_load;
  logic [DW-1:0] rf_base_data, alu_result;
  logic [DW-1:0] bus_out, pc_out, mar_out, mdr_out, ir_out;
  logic br_taken;

  int checks = 0;
  int failures = 0;

  // Bench-side model of the architectural state
  logic [DW-1:0] m_pc, m_mar, m_mdr, m_ir;
  logic [2:0]    m_cc;
  logic [DW-1:0] m_mem [DEPTH];

  always #5 clk = ~clk;

  bus_addr_datapath #(.DW(DW), .AW(AW)) dut (
    .clk(clk), .rst_n(rst_n),
    .drv_pc(drv_pc), .drv_mdr(drv_mdr), .drv_alu(drv_alu), .drv_ea(drv_ea),
    .ea_base_sel(ea_base_sel), .ea_ofs_sel(ea_ofs_sel), .pc_src_sel(pc_src_sel),
    .pc_load(pc_load), .mar_load(mar_load), .mdr_load(mdr_load),
    .mdr_src_sel(mdr_src_sel), .ir_load(ir_load), .mem_wr(mem_wr), .cc_load(cc_load),
    .rf_base_data(rf_base_data), .alu_result(alu_result),
    .bus_out(bus_out), .pc_out(pc_out), .mar_out(mar_out), .mdr_out(mdr_out),
    .ir_out(ir_out), .br_taken(br_taken)
  );

  function automatic logic [DW-1:0] exp_ea();
    logic [DW-1:0] a, b;
    a = ea_base_sel ? rf_base_data : m_pc;
    case (ea_ofs_sel)
      2'b01:   b = {{10{m_ir[5]}}, m_ir[5:0]};
      2'b10:   b = {{7{m_ir[8]}}, m_ir[8:0]};
      default: b = '0;
    endcase
    return a + b;
  endfunction

  function automatic logic [DW-1:0] exp_bus();
    if (drv_pc)  return m_pc;
    if (drv_mdr) return m_mdr;
    if (drv_alu) return alu_result;
    if (drv_ea)  return exp_ea();
    return '0;
  endfunction

  function automatic logic [2:0] exp_flags(input logic [DW-1:0] v);
    if (v[DW-1]) return 3'b100;
    if (v == '0) return 3'b010;
    return 3'b001;
  endfunction

  function automatic logic exp_taken();
    return |(m_ir[11:9] & m_cc);
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    drv_pc = 0; drv_mdr = 0; drv_alu = 0; drv_ea = 0;
    ea_base_sel = 0; ea_ofs_sel = 2'b00; pc_src_sel = 2'b00;
    pc_load = 0; mar_load = 0; mdr_load = 0; mdr_src_sel = 0;
    ir_load = 0; mem_wr = 0; cc_load = 0;
  endtask

  // Advance one clock, updating the model from the controls applied
  task automatic tick();
    logic [DW-1:0] b, n_pc, n_mar, n_mdr, n_ir;
    logic [2:0] n_cc;
    b = exp_bus();
    n_pc = m_pc; n_mar = m_mar; n_mdr = m_mdr; n_ir = m_ir; n_cc = m_cc;
    if (pc_load) begin
      if (pc_src_sel == 2'b00) n_pc = m_pc + 1'b1;
      else if (pc_src_sel == 2'b01) n_pc = exp_ea();
    end
    if (mar_load) n_mar = b;
    if (mdr_load) n_mdr = mdr_src_sel ? m_mem[m_mar[AW-1:0]] : b;
    if (ir_load) n_ir = b;
    if (cc_load) n_cc = exp_flags(b);
    if (mem_wr) m_mem[m_mar[AW-1:0]] = m_mdr;
    @(posedge clk);
    #1;
    m_pc = n_pc; m_mar = n_mar; m_mdr = n_mdr; m_ir = n_ir; m_cc = n_cc;
  endtask

  task automatic via_alu_ir(input logic [DW-1:0] v);
    idle(); alu_result = v; drv_alu = 1; ir_load = 1; tick(); idle();
  endtask
  task automatic via_alu_mar(input logic [DW-1:0] v);
    idle(); alu_result = v; drv_alu = 1; mar_load = 1; tick(); idle();
  endtask
  task automatic via_alu_mdr(input logic [DW-1:0] v);
    idle(); alu_result = v; drv_alu = 1; mdr_load = 1; mdr_src_sel = 0; tick(); idle();
  endtask
  task automatic set_pc(input logic [DW-1:0] v);
    idle(); rf_base_data = v; ea_base_sel = 1; ea_ofs_sel = 2'b00;
    pc_src_sel = 2'b01; pc_load = 1; tick(); idle();
  endtask

  initial begin : watchdog
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    idle();
    rf_base_data = '0; alu_result = '0;
    m_pc = '0; m_mar = '0; m_mdr = '0; m_ir = '0; m_cc = 3'b010;
    for (int i = 0; i < DEPTH; i++) m_mem[i] = '0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    #1;

    // R1 reset state
    chk("R1 pc", pc_out, 16'h0000);
    chk("R1 mar", mar_out, 16'h0000);
    chk("R1 mdr", mdr_out, 16'h0000);
    chk("R1 ir", ir_out, 16'h0000);
    via_alu_ir(16'h0400);
    chk("R1 zero flag after reset", {15'd0, br_taken}, 16'd1);
    via_alu_ir(16'h0A00);
    chk("R1 n/p clear after reset", {15'd0, br_taken}, 16'd0);

    // R2 bus sources
    idle(); #1;
    chk("R2 idle bus", bus_out, 16'h0000);
    alu_result = 16'hBEEF; drv_alu = 1; #1;
    chk("R2 alu on bus", bus_out, 16'hBEEF);
    set_pc(16'h3000);
    drv_pc = 1; #1;
    chk("R2 pc on bus", bus_out, 16'h3000);
    via_alu_mdr(16'h1234);
    drv_mdr = 1; #1;
    chk("R2 mdr on bus", bus_out, 16'h1234);
    idle();

    // R4 offset sign boundaries, R3 base choice
    via_alu_ir(16'h0020);   // IR[5:0] = 100000 -> -32
    ea_base_sel = 0; ea_ofs_sel = 2'b01; drv_ea = 1; #1;
    chk("R4 short min", bus_out, 16'h3000 - 16'd32);
    via_alu_ir(16'h00FF);   // IR[8:0] = 0_1111_1111 -> +255
    ea_base_sel = 1; rf_base_data = 16'hFFF0; ea_ofs_sel = 2'b10; drv_ea = 1; #1;
    chk("R3 R4 long max wrap", bus_out, 16'h00EF);
    ea_ofs_sel = 2'b11; #1;
    chk("R4 reserved sel zero", bus_out, 16'hFFF0);
    idle();

    // R5 hold encodings
    set_pc(16'h4000);
    pc_load = 1; pc_src_sel = 2'b10; tick(); idle();
    chk("R5 src 10 holds", pc_out, 16'h4000);
    pc_load = 0; pc_src_sel = 2'b01; tick(); idle();
    chk("R5 no load holds", pc_out, 16'h4000);

    // Randomized address / PC mix: R3 R4 R5 R6
    begin
      int unsigned seed;
      seed = $urandom(32'h5EED_0042);
      for (int it = 0; it < 300; it++) begin
        logic [DW-1:0] e;
        via_alu_ir(16'($urandom));
        chk("R6 ir capture", ir_out, m_ir);
        rf_base_data = 16'($urandom);
        ea_base_sel = 1'($urandom);
        ea_ofs_sel = 2'($urandom);
        drv_ea = 1; #1;
        e = exp_ea();
        chk("R3 R4 ea on bus", bus_out, e);
        pc_load = 1'($urandom);
        pc_src_sel = 2'($urandom);
        mar_load = 1'($urandom);
        tick();
        chk("R5 pc update", pc_out, m_pc);
        chk("R6 mar update", mar_out, m_mar);
        idle();
      end
    end

    // R7 R8 memory write and read-back, including alias above AW bits
    for (int a = 0; a < 16; a++) begin
      logic [DW-1:0] d;
      d = 16'($urandom) ^ 16'(a);
      via_alu_mar(16'(a * 3));
      via_alu_mdr(d);
      chk("R7 mdr from bus", mdr_out, d);
      mem_wr = 1; tick(); idle();
    end
    for (int a = 0; a < 16; a++) begin
      via_alu_mar(16'(a * 3 + 64));
      mdr_load = 1; mdr_src_sel = 1; tick(); idle();
      chk("R8 readback via alias", mdr_out, m_mem[(a * 3) % DEPTH]);
    end
    // write and MDR reload in the same edge: memory takes old MDR
    via_alu_mar(16'h0005);
    via_alu_mdr(16'hA5A5);
    alu_result = 16'h5A5A; drv_alu = 1; mdr_load = 1; mem_wr = 1; tick(); idle();
    chk("R7 mdr new value", mdr_out, 16'h5A5A);
    mdr_load = 1; mdr_src_sel = 1; tick(); idle();
    chk("R8 stored old mdr", mdr_out, 16'hA5A5);

    // R9 R10 flags and branch test
    begin
      logic [DW-1:0] vals [5];
      vals[0] = 16'h8000; vals[1] = 16'h0000; vals[2] = 16'h7FFF;
      vals[3] = 16'hFFFF; vals[4] = 16'h0001;
      for (int v = 0; v < 5; v++) begin
        alu_result = vals[v]; drv_alu = 1; cc_load = 1; tick(); idle();
        for (int m = 0; m < 8; m++) begin
          via_alu_ir(16'(m << 9));
          chk("R9 R10 branch vs flags", {15'd0, br_taken}, {15'd0, exp_taken()});
        end
      end
      // no cc_load: flags hold even though bus is negative
      alu_result = 16'h0001; drv_alu = 1; cc_load = 1; tick(); idle();
      alu_result = 16'h8000; drv_alu = 1; tick(); idle();
      via_alu_ir(16'h0200);
      chk("R9 flags hold without load", {15'd0, br_taken}, 16'd1);
    end

    // R11 fetch sequence then PC-relative address
    via_alu_mar(16'h0010);
    via_alu_mdr(16'h01FE);   // IR[8:0] = 1_1111_1110 -> -2
    mem_wr = 1; tick(); idle();
    set_pc(16'h0010);
    drv_pc = 1; mar_load = 1; tick(); idle();
    mdr_load = 1; mdr_src_sel = 1; pc_load = 1; pc_src_sel = 2'b00; tick(); idle();
    chk("R11 pc incremented", pc_out, 16'h0011);
    drv_mdr = 1; ir_load = 1; tick(); idle();
    chk("R11 ir fetched", ir_out, 16'h01FE);
    ea_base_sel = 0; ea_ofs_sel = 2'b10; drv_ea = 1; #1;
    chk("R11 pc-relative from next", bus_out, 16'h000F);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule